// File: doc/BRIEF.md
# Chainable Down-Counter Timer Pair

A pair of programmable timers on one system clock. The narrow half (24 bits) and the wide half (32 bits) each pick one of four timebase strobes, count down from a reload value, reload themselves when they run out, and can flag a terminal-count interrupt. A join bit on the narrow half turns the pair into one 56-bit counter. In that mode the narrow half expiring advances the wide half. The wide half ignores its own strobe and reads back as an incrementing value, the bitwise inverse of its internal count.

Software programs the block through a small word-wide write port and a combinational read port. The address map, by register: 0 narrow control, 1 narrow timebase select, 2 narrow reload, 3 narrow observed count (read only), 4 wide control, 5 wide timebase select, 6 wide reload, 7 wide observed count (read only), 8 interrupt status. Control bits: bit 0 run, bit 1 restart (a write-only strobe that reads as 0), bit 2 interrupt enable, bit 3 join (narrow half only). Status bit 0 belongs to the narrow half and bit 1 to the wide half.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, both observed counts (addresses 3 and 7), the status register (address 8) and both interrupt outputs are zero.
- R2: A timebase select value of 0, 1, 2 or 3 makes a standalone half count only on tick_i[0] (32.768 kHz), tick_i[1] (1.024 kHz), tick_i[2] (32 Hz) or tick_i[3] (8 MHz) respectively.
- R3: While control bit 0 is clear, a half's count does not change on its selected tick.
- R4: Writing a reload register does not change the count. The count takes the reload value only when control bit 1 is written as 1, or at the next automatic reload.
- R5: In standalone operation, each selected tick lowers the count by one. A tick that finds the count at 1 or 0 reloads the count instead and signals an expiry.
- R6: With join (narrow control bit 3) set, the wide half advances once per narrow expiry, ignores its own tick, and reads at address 7 as the bitwise inverse of its internal count. Right after a restart it reads as the inverse of its reload value.
- R7: In joined mode, an advance while the wide half's observed value is all ones reloads the wide half, so it reads as the inverse of its reload value, and signals a wide expiry.
- R8: With join clear, the wide half counts down on its own selected tick and reads back uninverted.
- R9: An expiry sets its status bit (bit 0 narrow, bit 1 wide) when that half's control bit 2 is set. irq_lo_o and irq_hi_o follow status bits 0 and 1.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R11: A narrow restart written with the join bit set also reloads the wide half.
- R12: A restart in the same cycle as a selected tick loads the reload value and signals no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 4 | Single-cycle timebase strobes, one per select code |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| irq_lo_o | output | 1 | Narrow half interrupt flag |
| irq_hi_o | output | 1 | Wide half interrupt flag |

## Verification
The assertions assume that every timebase strobe lasts exactly one clock, that writes are single-cycle strobes whose data is valid in that cycle, and that a restart or a write to a reload register may land in any cycle, including the cycle of a tick. The stimulus drives strobes and writes one clock wide on the falling edge. It deliberately puts a restart on the same edge as a tick and a status clear on the same edge as an expiry, so the ordering rules are exercised, not avoided.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_LO_CTRL = 4'd0;
  localparam logic [REG_AW-1:0] A_LO_SEL  = 4'd1;
  localparam logic [REG_AW-1:0] A_LO_LOAD = 4'd2;
  localparam logic [REG_AW-1:0] A_LO_OBS  = 4'd3;
  localparam logic [REG_AW-1:0] A_HI_CTRL = 4'd4;
  localparam logic [REG_AW-1:0] A_HI_SEL  = 4'd5;
  localparam logic [REG_AW-1:0] A_HI_LOAD = 4'd6;
  localparam logic [REG_AW-1:0] A_HI_OBS  = 4'd7;
  localparam logic [REG_AW-1:0] A_STATUS  = 4'd8;

  localparam int CB_RUN     = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_IE      = 2;
  localparam int CB_JOIN    = 3;

  localparam int HALF_LO = 0;
  localparam int HALF_HI = 1;
  localparam int NHALF   = 2;
endpackage

// File: rtl/tp_tick_sel.sv
module tp_tick_sel #(
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] tick_i,
  input  logic [SELW-1:0] sel_i,
  output logic            tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SELW'(i)) tick_o = tick_i[i];
    end
  end
endmodule

// File: rtl/tp_count_cell.sv
module tp_count_cell #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         adv_i,
  input  logic         chain_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         exp_c;

  always_comb begin
    cnt_d = cnt_q;
    exp_c = 1'b0;
    if (restart_i) begin
      cnt_d = load_i;
    end else if (adv_i) begin
      if (chain_i) begin
        if (cnt_q == '0) begin
          cnt_d = load_i;
          exp_c = 1'b1;
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end else begin
        if (cnt_q <= W'(1)) begin
          cnt_d = load_i;
          exp_c = 1'b1;
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_c;

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == $past(load_i));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !restart_i && !chain_i && cnt_q > W'(1)) |=> cnt_q == $past(cnt_q) - W'(1));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tp_irq_flags.sv
module tp_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;

  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_q[g]);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_q[g]);
  end
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import timer_pair_pkg::*;
#(
  parameter int LO_W = 24,
  parameter int HI_W = 32,
  parameter int NSRC = 4,
  parameter int DW   = 32,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_i,
  input  logic            wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            irq_lo_o,
  output logic            irq_hi_o
);
  // configuration state
  logic            run_q   [NHALF];
  logic            run_d   [NHALF];
  logic            ie_q    [NHALF];
  logic            ie_d    [NHALF];
  logic [SELW-1:0] sel_q   [NHALF];
  logic [SELW-1:0] sel_d   [NHALF];
  logic            join_q, join_d;
  logic [LO_W-1:0] lo_load_q, lo_load_d;
  logic [HI_W-1:0] hi_load_q, hi_load_d;

  // write decode
  logic wr_lo_ctrl, wr_hi_ctrl, wr_lo_sel, wr_hi_sel;
  logic wr_lo_load, wr_hi_load, wr_stat;

  always_comb begin
    wr_lo_ctrl = wr_en_i && (wr_addr_i == A_LO_CTRL);
    wr_hi_ctrl = wr_en_i && (wr_addr_i == A_HI_CTRL);
    wr_lo_sel  = wr_en_i && (wr_addr_i == A_LO_SEL);
    wr_hi_sel  = wr_en_i && (wr_addr_i == A_HI_SEL);
    wr_lo_load = wr_en_i && (wr_addr_i == A_LO_LOAD);
    wr_hi_load = wr_en_i && (wr_addr_i == A_HI_LOAD);
    wr_stat    = wr_en_i && (wr_addr_i == A_STATUS);
  end

  // next-state for configuration
  always_comb begin
    for (int h = 0; h < NHALF; h++) begin
      run_d[h] = run_q[h];
      ie_d[h]  = ie_q[h];
      sel_d[h] = sel_q[h];
    end
    join_d    = join_q;
    lo_load_d = lo_load_q;
    hi_load_d = hi_load_q;
    if (wr_lo_ctrl) begin
      run_d[HALF_LO] = wr_data_i[CB_RUN];
      ie_d[HALF_LO]  = wr_data_i[CB_IE];
      join_d         = wr_data_i[CB_JOIN];
    end
    if (wr_hi_ctrl) begin
      run_d[HALF_HI] = wr_data_i[CB_RUN];
      ie_d[HALF_HI]  = wr_data_i[CB_IE];
    end
    if (wr_lo_sel)  sel_d[HALF_LO] = wr_data_i[SELW-1:0];
    if (wr_hi_sel)  sel_d[HALF_HI] = wr_data_i[SELW-1:0];
    if (wr_lo_load) lo_load_d = wr_data_i[LO_W-1:0];
    if (wr_hi_load) hi_load_d = wr_data_i[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < NHALF; h++) begin
        run_q[h] <= 1'b0;
        ie_q[h]  <= 1'b0;
        sel_q[h] <= '0;
      end
      join_q    <= 1'b0;
      lo_load_q <= '0;
      hi_load_q <= '0;
    end else begin
      for (int h = 0; h < NHALF; h++) begin
        run_q[h] <= run_d[h];
        ie_q[h]  <= ie_d[h];
        sel_q[h] <= sel_d[h];
      end
      join_q    <= join_d;
      lo_load_q <= lo_load_d;
      hi_load_q <= hi_load_d;
    end
  end

  // timebase selection per half
  logic [NHALF-1:0] half_tick;

  for (genvar g = 0; g < NHALF; g++) begin : g_tsel
    tp_tick_sel #(.NSRC(NSRC)) u_tsel (
      .tick_i (tick_i),
      .sel_i  (sel_q[g]),
      .tick_o (half_tick[g])
    );
  end

  // counting halves
  logic            restart_lo, restart_hi;
  logic            adv_lo, adv_hi;
  logic            exp_lo, exp_hi;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  always_comb begin
    restart_lo = wr_lo_ctrl && wr_data_i[CB_RESTART];
    restart_hi = (wr_hi_ctrl && wr_data_i[CB_RESTART]) ||
                 (restart_lo && wr_data_i[CB_JOIN]);
    adv_lo     = run_q[HALF_LO] && half_tick[HALF_LO];
    adv_hi     = join_q ? (run_q[HALF_HI] && exp_lo)
                        : (run_q[HALF_HI] && half_tick[HALF_HI]);
  end

  tp_count_cell #(.W(LO_W)) u_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_lo),
    .adv_i     (adv_lo),
    .chain_i   (1'b0),
    .load_i    (lo_load_q),
    .cnt_o     (lo_cnt),
    .expire_o  (exp_lo)
  );

  tp_count_cell #(.W(HI_W)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_hi),
    .adv_i     (adv_hi),
    .chain_i   (join_q),
    .load_i    (hi_load_q),
    .cnt_o     (hi_cnt),
    .expire_o  (exp_hi)
  );

  // interrupt status
  logic [NHALF-1:0] flag_set, flag_clr, flags;

  always_comb begin
    flag_set[HALF_LO] = exp_lo && ie_q[HALF_LO];
    flag_set[HALF_HI] = exp_hi && ie_q[HALF_HI];
    flag_clr          = wr_stat ? wr_data_i[NHALF-1:0] : '0;
  end

  tp_irq_flags #(.N(NHALF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  assign irq_lo_o = flags[HALF_LO];
  assign irq_hi_o = flags[HALF_HI];

  // read path
  logic [HI_W-1:0] hi_obs;

  always_comb begin
    hi_obs    = join_q ? ~hi_cnt : hi_cnt;
    rd_data_o = '0;
    case (rd_addr_i)
      A_LO_CTRL: begin
        rd_data_o[CB_RUN]  = run_q[HALF_LO];
        rd_data_o[CB_IE]   = ie_q[HALF_LO];
        rd_data_o[CB_JOIN] = join_q;
      end
      A_HI_CTRL: begin
        rd_data_o[CB_RUN]  = run_q[HALF_HI];
        rd_data_o[CB_IE]   = ie_q[HALF_HI];
      end
      A_LO_SEL:  rd_data_o = DW'(sel_q[HALF_LO]);
      A_HI_SEL:  rd_data_o = DW'(sel_q[HALF_HI]);
      A_LO_LOAD: rd_data_o = DW'(lo_load_q);
      A_HI_LOAD: rd_data_o = DW'(hi_load_q);
      A_LO_OBS:  rd_data_o = DW'(lo_cnt);
      A_HI_OBS:  rd_data_o = DW'(hi_obs);
      A_STATUS:  rd_data_o = DW'(flags);
      default:   rd_data_o = '0;
    endcase
  end

  // R6
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_q && !exp_lo && !restart_hi) |=> $stable(hi_cnt));

  // R9
  irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_lo && ie_q[HALF_LO]) |=> irq_lo_o);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_q && exp_lo && run_q[HALF_HI] && !restart_hi && hi_cnt == '0)
      |=> hi_cnt == $past(hi_load_q));

  // R12
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_lo |-> !exp_lo);
endmodule

// File: tb/cascade_timer_pair_bench.sv
`timescale 1ns/1ps
module cascade_timer_pair_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  tick_i;
  logic        wr_en_i;
  logic [3:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [3:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic        irq_lo_o, irq_hi_o;

  cascade_timer_pair u_cascade_timer_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_lo_o  (irq_lo_o),
    .irq_hi_o  (irq_hi_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit summed = 1'b0;

  // monitor: pops one expected item per cycle, between falling and rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {30'd0, irq_hi_o, irq_lo_o} : rd_data_o;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] a, input logic [31:0] d,
                       input bit we, input int tk);
    @(negedge clk);
    wr_en_i   = we;
    wr_addr_i = a;
    wr_data_i = d;
    tick_i    = (tk >= 0) ? 4'(1 << tk) : 4'd0;
    @(negedge clk);
    wr_en_i = 1'b0;
    tick_i  = 4'd0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(a, d, 1'b1, -1);
  endtask

  task automatic tk(input int idx);
    drive(4'd0, 32'd0, 1'b0, idx);
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {30'd0, e}; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!summed) begin
      summed = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = '0; wr_en_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(4'd3, 32'd0, "R1 lo obs");
    chk(4'd7, 32'd0, "R1 hi obs");
    chk(4'd8, 32'd0, "R1 status");
    chk_irq(2'b00, "R1 irq");

    wr(4'd1, 32'd1);
    wr(4'd2, 32'd5);
    chk(4'd3, 32'd0, "R4 load write alone");
    wr(4'd0, 32'b0111);
    chk(4'd3, 32'd5, "R4 restart loads");
    tk(0);
    chk(4'd3, 32'd5, "R2 unselected tick");
    tk(1);
    chk(4'd3, 32'd4, "R2 R5 selected tick");

    wr(4'd0, 32'b0100);
    tk(1);
    chk(4'd3, 32'd4, "R3 stopped");
    wr(4'd0, 32'b0101);
    tk(1);
    chk(4'd3, 32'd3, "R3 running again");
    tk(1); tk(1); tk(1);
    chk(4'd3, 32'd5, "R5 reload on expiry");
    chk(4'd8, 32'd1, "R9 lo status");
    chk_irq(2'b01, "R9 irq lo");

    wr(4'd8, 32'd2);
    chk(4'd8, 32'd1, "R10 write zero keeps");
    wr(4'd8, 32'd1);
    chk(4'd8, 32'd0, "R10 write one clears");

    tk(1); tk(1); tk(1); tk(1);
    chk(4'd3, 32'd1, "R5 count at one");
    drive(4'd0, 32'b0111, 1'b1, 1);
    chk(4'd3, 32'd5, "R12 restart beats tick");
    chk(4'd8, 32'd0, "R12 no expiry");

    tk(1); tk(1); tk(1); tk(1);
    drive(4'd8, 32'd1, 1'b1, 1);
    chk(4'd8, 32'd1, "R10 set wins over clear");
    wr(4'd8, 32'd1);

    wr(4'd5, 32'd3);
    wr(4'd6, 32'd3);
    wr(4'd4, 32'b0111);
    chk(4'd7, 32'd3, "R8 hi uninverted");
    tk(3);
    chk(4'd7, 32'd2, "R8 hi own tick");
    tk(1);
    chk(4'd7, 32'd2, "R8 hi ignores lo tick");
    tk(3); tk(3);
    chk(4'd7, 32'd3, "R8 hi reload");
    chk(4'd8, 32'd2, "R9 hi status");
    chk_irq(2'b10, "R9 irq hi");
    wr(4'd8, 32'd2);

    wr(4'd4, 32'b0101);
    wr(4'd2, 32'd2);
    wr(4'd6, 32'd1);
    wr(4'd0, 32'b1111);
    chk(4'd3, 32'd2, "R11 lo restart");
    chk(4'd7, 32'hFFFF_FFFE, "R11 R6 hi restarts inverted");
    tk(3);
    chk(4'd7, 32'hFFFF_FFFE, "R6 hi own tick ignored");
    tk(1);
    chk(4'd3, 32'd1, "R6 lo counts");
    chk(4'd7, 32'hFFFF_FFFE, "R6 hi waits for expiry");
    tk(1);
    chk(4'd7, 32'hFFFF_FFFF, "R6 hi advances");
    chk(4'd8, 32'd1, "R6 lo expiry flag");
    wr(4'd6, 32'd5);
    chk(4'd7, 32'hFFFF_FFFF, "R4 hi load deferred");
    tk(1); tk(1);
    chk(4'd7, 32'hFFFF_FFFA, "R7 hi wrap to inverse load");
    chk(4'd8, 32'd3, "R7 hi expiry flag");
    chk_irq(2'b11, "R7 irq both");
    wr(4'd8, 32'd3);
    chk(4'd8, 32'd0, "R10 clear both");
    chk_irq(2'b00, "R10 irq cleared");

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule